// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a RISC core whose procedure calls slide a window over a circular stack of physical registers. At any moment software addresses 32 architectural registers with 5-bit indices. Indices 0 to 7 name eight globals that every window sees. Indices 8 to 31 name 24 windowed registers that are remapped through a current window pointer (CWP). Index 0 is a constant zero.

A call asserts `save_i` and moves the window one step forward. A return asserts `restore_i` and moves it one step back. The step is taken modulo the configured window count `NWIN`, which may be from 3 to 32. Each window owns eight locals. Its eight outs are the same physical registers as the ins of the next window forward, so arguments pass to the callee and results come back without any copying. Each window therefore costs 16 physical registers, and the store holds 8 + 16·NWIN registers in total (136 at the default of 8 windows).

An invalid-window mask, loaded as a whole through `wim_we_i`, marks windows that must not be entered. A save or restore whose target is marked raises a one-cycle overflow or underflow flag and leaves the pointer where it was. Spill and fill handling is left to the surrounding core. The register file has no valid/ready streams: reads are combinational, the write and all controls are sampled at the rising clock edge, and there is no back-pressure.

Top module: `wrf_top`

## Requirements
- R1: The two read ports are independent and combinational: `rd0_o` and `rd1_o` show the registers named by `ra0_i` and `ra1_i` in the same cycle, even when the two indices differ.
- R2: Index 0 always reads 0 on both ports, and a write to index 0 changes nothing.
- R3: Indices 0 to 7 name the same eight global registers in every window, so a global written in one window reads back unchanged after any save or restore.
- R4: Indices 16 to 23 are locals private to the current window: writing them in one window leaves the locals of every other window unchanged.
- R5: Outs (indices 8 to 15) of window w are the same physical registers as ins (indices 24 to 31) of window (w+1) mod NWIN. A value written to out k before a save reads back at in k after it, and a value written to in k before a restore reads back at out k after it.
- R6: Reset puts the pointer at 0, clears both flags and clears every register. A save sets `cwp_o` to (cwp+1) mod NWIN and a restore sets it to (cwp−1) mod NWIN, both at the next edge.
- R7: A save whose target window has its mask bit set leaves `cwp_o` unchanged and raises `ovf_o` for exactly the following cycle. Register contents are untouched.
- R8: A restore whose target window has its mask bit set leaves `cwp_o` unchanged and raises `unf_o` for exactly the following cycle.
- R9: A write lands at the clock edge. A read of the register being written in the same cycle returns the old value until that edge.
- R10: When `save_i` and `restore_i` are both high in one cycle, the pointer holds and neither flag rises.
- R11: `wim_we_i` replaces the whole mask with `wim_i` (bit n marks window n). The mask resets to all clear, and a cleared bit lets the window be entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra0_i | input | 5 | Read port 0 architectural index |
| rd0_o | output | XLEN | Read port 0 data |
| ra1_i | input | 5 | Read port 1 architectural index |
| rd1_o | output | XLEN | Read port 1 data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write architectural index, mapped through the current window |
| wd_i | input | XLEN | Write data |
| save_i | input | 1 | Advance the window (call) |
| restore_i | input | 1 | Retreat the window (return) |
| wim_we_i | input | 1 | Load the invalid-window mask |
| wim_i | input | NWIN | New invalid-window mask |
| cwp_o | output | clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Save blocked by the mask, pulse one cycle |
| unf_o | output | 1 | Restore blocked by the mask, pulse one cycle |

## Verification
The pointer assertions assume the controls are clean levels sampled once per edge. They also assume that a save and a restore arriving together are a deliberate no-op rather than something the block must resolve. Every bench task drives at most one of the two per cycle, except the one task that checks the no-op. The properties also assume the mask does not change in the same cycle as a save or restore. The bench therefore loads the mask in a cycle of its own before it moves the window against it. Every input changes only a couple of nanoseconds after a rising edge, so the registered flags and the combinational reads have settled when they are sampled.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
  localparam int NUM_GLOBALS = 8;
  localparam int WIN_REGS    = 16;   // physical registers owned by one window
  localparam int IDX_W       = 5;

  typedef enum logic [1:0] {
    RGN_GLOBAL = 2'd0,
    RGN_OUT    = 2'd1,
    RGN_LOCAL  = 2'd2,
    RGN_IN     = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [IDX_W-1:0] idx);
    return region_e'(idx[4:3]);
  endfunction
endpackage

// File: rtl/wrf_index_map.sv
`timescale 1ns/1ps
module wrf_index_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CWPW = $clog2(NWIN),
  localparam int PHYS = NUM_GLOBALS + WIN_REGS * NWIN,
  localparam int PW   = $clog2(PHYS)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CWPW-1:0]  cwp_i,
  output logic [PW-1:0]    phys_o
);
  int cur;
  int nxt;
  int off;
  int slot;

  always_comb begin
    cur = int'(cwp_i);
    nxt = (cur == NWIN - 1) ? 0 : cur + 1;
    off = int'(idx_i[2:0]);
    unique case (region_of(idx_i))
      RGN_GLOBAL: slot = off;
      RGN_OUT:    slot = NUM_GLOBALS + WIN_REGS * nxt + 8 + off;
      RGN_LOCAL:  slot = NUM_GLOBALS + WIN_REGS * cur + off;
      default:    slot = NUM_GLOBALS + WIN_REGS * cur + 8 + off;
    endcase
    phys_o = PW'(slot);
  end
endmodule

// File: rtl/wrf_window_ctl.sv
`timescale 1ns/1ps
module wrf_window_ctl #(
  parameter int NWIN = 8,
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            wim_we_i,
  input  logic [NWIN-1:0] wim_i,
  output logic [CWPW-1:0] cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam logic [CWPW-1:0] LAST = CWPW'(NWIN - 1);

  logic [CWPW-1:0] cwp_q, fwd, bwd;
  logic [NWIN-1:0] wim_q;
  logic            save_only, rest_only, fwd_blocked, bwd_blocked;

  assign fwd         = (cwp_q == LAST) ? '0 : cwp_q + 1'b1;
  assign bwd         = (cwp_q == '0) ? LAST : cwp_q - 1'b1;
  assign save_only   = save_i & ~restore_i;
  assign rest_only   = restore_i & ~save_i;
  assign fwd_blocked = wim_q[fwd];
  assign bwd_blocked = wim_q[bwd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      wim_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= save_only & fwd_blocked;
      unf_o <= rest_only & bwd_blocked;
      if (save_only && !fwd_blocked)      cwp_q <= fwd;
      else if (rest_only && !bwd_blocked) cwp_q <= bwd;
      if (wim_we_i) wim_q <= wim_i;
    end
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/wrf_storage.sv
`timescale 1ns/1ps
module wrf_storage #(
  parameter int PHYS = 136,
  parameter int XLEN = 32,
  parameter int NRD  = 2,
  localparam int PW  = $clog2(PHYS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [PW-1:0]             waddr_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [NRD-1:0][PW-1:0]    raddr_i,
  output logic [NRD-1:0][XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] regs [PHYS];

  // physical slot 0 is the constant-zero global; no storage behind it
  assign regs[0] = '0;

  for (genvar g = 1; g < PHYS; g++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= '0;
      else if (we_i && waddr_i == PW'(g))    q <= wdata_i;
    end
    assign regs[g] = q;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] < PW'(PHYS)) ? regs[raddr_i[p]] : '0;
  end
endmodule

// File: rtl/wrf_top.sv
`timescale 1ns/1ps
module wrf_top
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CWPW = $clog2(NWIN),
  localparam int PHYS = NUM_GLOBALS + WIN_REGS * NWIN,
  localparam int PW   = $clog2(PHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       ra0_i,
  output logic [XLEN-1:0]  rd0_o,
  input  logic [4:0]       ra1_i,
  output logic [XLEN-1:0]  rd1_o,
  input  logic             we_i,
  input  logic [4:0]       wa_i,
  input  logic [XLEN-1:0]  wd_i,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             wim_we_i,
  input  logic [NWIN-1:0]  wim_i,
  output logic [CWPW-1:0]  cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int NRD  = 2;
  localparam int NMAP = NRD + 1;   // read ports then the write port

  logic [NMAP-1:0][IDX_W-1:0] arch_idx;
  logic [NMAP-1:0][PW-1:0]    phys_idx;
  logic [NRD-1:0][PW-1:0]     rd_phys;
  logic [NRD-1:0][XLEN-1:0]   rd_data;
  logic [CWPW-1:0]            cwp;
  logic                       wen;

  assign arch_idx[0] = ra0_i;
  assign arch_idx[1] = ra1_i;
  assign arch_idx[2] = wa_i;

  wrf_window_ctl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
    .wim_we_i(wim_we_i), .wim_i(wim_i), .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    wrf_index_map #(.NWIN(NWIN)) u_map (
      .idx_i(arch_idx[m]), .cwp_i(cwp), .phys_o(phys_idx[m])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rdsel
    assign rd_phys[p] = phys_idx[p];
  end

  assign wen = we_i & (wa_i != '0);

  wrf_storage #(.PHYS(PHYS), .XLEN(XLEN), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(wen), .waddr_i(phys_idx[NRD]),
    .wdata_i(wd_i), .raddr_i(rd_phys), .rdata_o(rd_data)
  );

  assign rd0_o = rd_data[0];
  assign rd1_o = rd_data[1];
  assign cwp_o = cwp;
endmodule

// File: rtl/wrf_checker.sv
`timescale 1ns/1ps
module wrf_checker #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CWPW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      ra0_i,
  input logic [XLEN-1:0] rd0_o,
  input logic [4:0]      ra1_i,
  input logic [XLEN-1:0] rd1_o,
  input logic            save_i,
  input logic            restore_i,
  input logic [CWPW-1:0] cwp_o,
  input logic            ovf_o,
  input logic            unf_o
);
  localparam logic [CWPW-1:0] LAST = CWPW'(NWIN - 1);
  logic [CWPW-1:0] up, dn;
  assign up = (cwp_o == LAST) ? '0 : cwp_o + 1'b1;
  assign dn = (cwp_o == '0) ? LAST : cwp_o - 1'b1;

  AST_ZERO_PORT0: assert property (@(posedge clk) disable iff (!rst_n) (ra0_i == '0) |-> (rd0_o == '0)); // R2
  AST_ZERO_PORT1: assert property (@(posedge clk) disable iff (!rst_n) (ra1_i == '0) |-> (rd1_o == '0)); // R2
  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cwp_o <= LAST); // R6
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !restore_i) |=> (ovf_o ? (cwp_o == $past(cwp_o)) : (cwp_o == $past(up)))); // R7
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !save_i) |=> (unf_o ? (cwp_o == $past(cwp_o)) : (cwp_o == $past(dn)))); // R8
  AST_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i == restore_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o)); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_o && unf_o)); // R7
endmodule

bind wrf_top wrf_checker #(.NWIN(NWIN), .XLEN(XLEN)) u_wrf_chk (
  .clk(clk), .rst_n(rst_n), .ra0_i(ra0_i), .rd0_o(rd0_o), .ra1_i(ra1_i), .rd1_o(rd1_o),
  .save_i(save_i), .restore_i(restore_i), .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/wrf_top_bench.sv
`timescale 1ns/1ps
module wrf_top_bench;
  localparam int NWIN = 8;
  localparam int XLEN = 32;

  logic clk = 0, rst_n = 0;
  logic [4:0] ra0 = 0, ra1 = 0, wa = 0;
  logic [XLEN-1:0] rd0, rd1, wd = 0;
  logic we = 0, save = 0, restore = 0, wim_we = 0;
  logic [NWIN-1:0] wim = 0;
  logic [2:0] cwp;
  logic ovf, unf;
  int checks = 0, failures = 0;
  logic [XLEN-1:0] v;

  always #10 clk = ~clk;

  wrf_top #(.NWIN(NWIN), .XLEN(XLEN)) u_wrf_top (
    .clk(clk), .rst_n(rst_n), .ra0_i(ra0), .rd0_o(rd0), .ra1_i(ra1), .rd1_o(rd1),
    .we_i(we), .wa_i(wa), .wd_i(wd), .save_i(save), .restore_i(restore),
    .wim_we_i(wim_we), .wim_i(wim), .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    we = 0; save = 0; restore = 0; wim_we = 0;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [XLEN-1:0] d);
    we = 1; wa = idx; wd = d; tick();
  endtask

  task automatic rd(input logic [4:0] idx, output logic [XLEN-1:0] d);
    ra0 = idx; #1; d = rd0;
  endtask

  task automatic do_save();    save = 1;    tick(); endtask
  task automatic do_restore(); restore = 1; tick(); endtask
  task automatic load_wim(input logic [NWIN-1:0] m); wim_we = 1; wim = m; tick(); endtask

  task automatic t_reset();
    chk("R6 cwp after reset", 32'(cwp), 0);
    chk("R6 ovf after reset", 32'(ovf), 0);
    chk("R6 unf after reset", 32'(unf), 0);
    rd(5'd20, v); chk("R6 reg clear after reset", v, 0);
  endtask

  task automatic t_zero();
    wr(5'd0, 32'hDEAD_BEEF);
    ra1 = 0; rd(5'd0, v);
    chk("R2 port0 zero", v, 0);
    chk("R2 port1 zero", rd1, 0);
  endtask

  task automatic t_ports();
    wr(5'd3, 32'hA1A1_0003);
    wr(5'd17, 32'hB2B2_0017);
    ra0 = 5'd3; ra1 = 5'd17; #1;
    chk("R1 port0 global", rd0, 32'hA1A1_0003);
    chk("R1 port1 local", rd1, 32'hB2B2_0017);
    ra1 = 5'd3; #1;
    chk("R1 port1 same reg", rd1, 32'hA1A1_0003);
  endtask

  task automatic t_globals();
    wr(5'd5, 32'h0C0C_0005);
    do_save();
    chk("R6 save advances", 32'(cwp), 1);
    rd(5'd5, v); chk("R3 global in window 1", v, 32'h0C0C_0005);
    do_restore();
    chk("R6 restore retreats", 32'(cwp), 0);
    rd(5'd5, v); chk("R3 global in window 0", v, 32'h0C0C_0005);
  endtask

  task automatic t_locals();
    wr(5'd18, 32'h1000_0018);
    do_save();
    rd(5'd18, v); chk("R4 window 1 local untouched", v, 0);
    wr(5'd18, 32'h1111_0018);
    do_restore();
    rd(5'd18, v); chk("R4 window 0 local kept", v, 32'h1000_0018);
    do_save();
    rd(5'd18, v); chk("R4 window 1 local kept", v, 32'h1111_0018);
    do_restore();
  endtask

  task automatic t_share();
    wr(5'd9, 32'hA7A7_0009);
    do_save();
    rd(5'd25, v); chk("R5 out becomes in", v, 32'hA7A7_0009);
    wr(5'd26, 32'h5E5E_001A);
    do_restore();
    rd(5'd10, v); chk("R5 in returns to out", v, 32'h5E5E_001A);
  endtask

  task automatic t_wrap();
    for (int k = 1; k <= NWIN; k++) begin
      if (k == NWIN) wr(5'd8, 32'h7777_0008);  // at window 7
      do_save();
      chk("R6 save modulo", 32'(cwp), k % NWIN);
    end
    rd(5'd24, v); chk("R5 window 7 outs are window 0 ins", v, 32'h7777_0008);
    do_restore();
    chk("R6 restore wraps", 32'(cwp), NWIN - 1);
    do_save();
    chk("R6 back to 0", 32'(cwp), 0);
  endtask

  task automatic t_overflow();
    load_wim(8'b0000_0010);
    do_save();
    chk("R7 ovf raised", 32'(ovf), 1);
    chk("R7 cwp held", 32'(cwp), 0);
    chk("R7 no unf", 32'(unf), 0);
    rd(5'd18, v); chk("R7 contents untouched", v, 32'h1000_0018);
    tick();
    chk("R7 ovf one cycle", 32'(ovf), 0);
  endtask

  task automatic t_underflow();
    load_wim(8'b1000_0000);
    do_restore();
    chk("R8 unf raised", 32'(unf), 1);
    chk("R8 cwp held", 32'(cwp), 0);
    tick();
    chk("R8 unf one cycle", 32'(unf), 0);
    load_wim('0);
    do_restore();
    chk("R11 cleared mask allows restore", 32'(cwp), NWIN - 1);
    chk("R11 no unf after clear", 32'(unf), 0);
    do_save();
    chk("R11 cleared mask allows save", 32'(cwp), 0);
  endtask

  task automatic t_rdw();
    ra0 = 5'd18; we = 1; wa = 5'd18; wd = 32'h4E4E_0018; #1;
    chk("R9 old value before edge", rd0, 32'h1000_0018);
    tick(); #1;
    chk("R9 new value after edge", rd0, 32'h4E4E_0018);
  endtask

  task automatic t_both();
    save = 1; restore = 1; tick();
    chk("R10 cwp holds", 32'(cwp), 0);
    chk("R10 no ovf", 32'(ovf), 0);
    chk("R10 no unf", 32'(unf), 0);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    @(posedge clk); #2;
    t_reset();
    t_zero();
    t_ports();
    t_globals();
    t_locals();
    t_share();
    t_wrap();
    t_overflow();
    t_underflow();
    t_rdw();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule